// File: doc/BRIEF.md
# Dual-Mode Tone and Beat Divider

This block sits after a synthesized oscillator whose frequency is 64 times a user-programmed number N. It divides that oscillator down so that the same number N drives a speaker stage in one of two ways. In pitch mode the block gives a square wave at N hertz. In metronome mode it gives one short beat pulse per period at N beats per minute.

A single 12-bit counter does both jobs. In pitch mode it runs freely and the output is taken from the bit that divides by 64. In metronome mode a synchronous early reset fires when the incremented value has bits 11, 10, 9 and 8 all set, so the counter spans 3840 values. The beat is a registered pulse of a fixed number of input cycles, starting at each wrap. When the mode input changes, the counter restarts from zero, so the first period in the new mode has full length. The low six counter bits and the top bit are brought out for production test.

Top module: `tone_beat_divider`

## Requirements
- R1: While `rst_n` is low, `spk_out`, `test_low` and `test_msb` are all 0, and the mode is held as pitch.
- R2: With `beat_mode` = 0 (pitch), `spk_out` equals counter bit 5. It is low for 32 input cycles and high for 32, giving a period of 64 cycles. Counting starts from 0 after reset.
- R3: With `beat_mode` = 1 (metronome), the counter spans 0 to 3839 and never holds 3840 or above. The beat period is therefore 3840 input cycles.
- R4: The early reset is synchronous and is decoded from the incremented value having bits 11..8 all high. The clock edge that would produce 3840 produces 0 instead. In pitch mode no early reset happens, and the counter passes 3840 and wraps from 4095 to 0.
- R5: In metronome mode, `spk_out` is high exactly while the counter is below 16. That makes a registered pulse 16 input cycles wide at the start of each beat period.
- R6: The first clock edge that sees `beat_mode` differ from the held mode sets the counter to 0 and adopts the new mode. The output on that edge already follows the new mode.
- R7: `test_low` shows counter bits 5..0 and `test_msb` shows counter bit 11, in the same cycle as `spk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, 64 times the programmed number |
| rst_n | input | 1 | Synchronous reset, active low |
| beat_mode | input | 1 | 0 selects pitch output, 1 selects metronome beat |
| spk_out | output | 1 | Registered drive to the speaker stage |
| test_low | output | 6 | Counter bits 5..0 for test |
| test_msb | output | 1 | Counter bit 11 for test |

## Verification
On every cycle the assertions check several things:
- the counter never reaches 3840 in metronome mode;
- the edge after 3839 gives 0;
- a mode change clears the counter;
- the counter otherwise steps by one;
- the output follows bit 5 in pitch mode, or the below-16 window in metronome mode.

Other behaviours can only be shown by the bench's scenarios. These are the absolute timing from reset, the pulse width and beat period measured over a whole 3840-cycle span, the counter running past 3840 in pitch mode, and the full-length first period after a mode switch made in the middle of a period.

// File: rtl/tbd_pkg.sv
// Shared types for the tone/beat divider.
package tbd_pkg;
    // Output interpretation selected by the mode input
    typedef enum logic {
        MODE_PITCH = 1'b0,
        MODE_BEAT  = 1'b1
    } tone_mode_e;
endpackage

// File: rtl/tbd_mode_track.sv
// Holds the mode in force and flags a change requested on the input.
// Assumes mode_i is synchronous to clk.
module tbd_mode_track
    import tbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_i,
    output tone_mode_e mode_q,
    output logic       mode_chg
);
    // Requested mode differs from the held one
    always_comb mode_chg = (tone_mode_e'(mode_i) != mode_q);

    // Adopt the requested mode each cycle; reset to pitch
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_PITCH;
        else        mode_q <= tone_mode_e'(mode_i);
    end
endmodule

// File: rtl/tbd_counter.sv
// Up counter with a synchronous clear and an optional early wrap at
// WRAP_AT, decoded from the set bits of WRAP_AT in the incremented value.
// Assumes the counter is below WRAP_AT whenever wrap_en is active, which
// holds because entering the wrapping mode clears it.
module tbd_counter #(
    parameter int CNT_W   = 12,
    parameter int WRAP_AT = 3840
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wrap_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);
    localparam logic [CNT_W-1:0] WRAP_MASK = CNT_W'(WRAP_AT);

    logic [CNT_W-1:0] inc;
    logic             wrap_hit;

    // Next value: clear, early wrap, or plain increment
    always_comb begin
        inc      = cnt_q + 1'b1;
        wrap_hit = wrap_en && ((inc & WRAP_MASK) == WRAP_MASK);
        if (clear || wrap_hit) cnt_d = '0;
        else                   cnt_d = inc;
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tbd_out_stage.sv
// Registered speaker drive: a tap bit in pitch mode, or a window on the
// counter start in beat mode. It works from the counter's next value, so
// the output lines up with the counter register.
module tbd_out_stage #(
    parameter int CNT_W     = 12,
    parameter int TAP_BIT   = 5,
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_sel,
    input  logic [CNT_W-1:0] cnt_d,
    output logic             spk_q
);
    localparam logic [CNT_W-1:0] PULSE_LIM = CNT_W'(PULSE_LEN);

    logic pulse_win;

    // Beat window; a zero length gives no pulse at all
    generate
        if (PULSE_LEN > 0) begin : g_pulse
            always_comb pulse_win = (cnt_d < PULSE_LIM);
        end else begin : g_nopulse
            always_comb pulse_win = 1'b0;
        end
    endgenerate

    // Register the selected source
    always_ff @(posedge clk) begin
        if (!rst_n) spk_q <= 1'b0;
        else        spk_q <= beat_sel ? pulse_win : cnt_d[TAP_BIT];
    end
endmodule

// File: rtl/tone_beat_divider.sv
// Divides the synthesized oscillator by 64 (pitch, Hz = N) or by 3840
// (metronome, BPM = N) with one shared counter.
// Assumes clk_osc runs at 64*N Hz, and that PITCH_DIV is a power of two
// no larger than 2**CNT_W.
module tone_beat_divider #(
    parameter int CNT_W     = 12,
    parameter int PITCH_DIV = 64,
    parameter int BEAT_DIV  = 3840,
    parameter int PULSE_LEN = 16
) (
    input  logic                         clk_osc,
    input  logic                         rst_n,
    input  logic                         beat_mode,
    output logic                         spk_out,
    output logic [$clog2(PITCH_DIV)-1:0] test_low,
    output logic                         test_msb
);
    import tbd_pkg::*;

    localparam int TAP_BIT = $clog2(PITCH_DIV) - 1;

    tone_mode_e       mode_q;
    logic             mode_chg;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    tbd_mode_track u_mode (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .mode_i   (beat_mode),
        .mode_q   (mode_q),
        .mode_chg (mode_chg)
    );

    tbd_counter #(
        .CNT_W   (CNT_W),
        .WRAP_AT (BEAT_DIV)
    ) u_cnt (
        .clk     (clk_osc),
        .rst_n   (rst_n),
        .clear   (mode_chg),
        .wrap_en (mode_q == MODE_BEAT),
        .cnt_q   (cnt_q),
        .cnt_d   (cnt_d)
    );

    tbd_out_stage #(
        .CNT_W     (CNT_W),
        .TAP_BIT   (TAP_BIT),
        .PULSE_LEN (PULSE_LEN)
    ) u_out (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .beat_sel (beat_mode),
        .cnt_d    (cnt_d),
        .spk_q    (spk_out)
    );

    // Test visibility of the counter
    always_comb begin
        test_low = cnt_q[TAP_BIT:0];
        test_msb = cnt_q[CNT_W-1];
    end
endmodule

// File: rtl/tbd_checker.sv
// Properties of the tone/beat divider, bound to its top module.
module tbd_checker #(
    parameter int CNT_W     = 12,
    parameter int TAP_BIT   = 5,
    parameter int BEAT_DIV  = 3840,
    parameter int PULSE_LEN = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             beat_mode,
    input logic             mode_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             spk_out
);
    localparam logic [CNT_W-1:0] LAST_VAL  = CNT_W'(BEAT_DIV - 1);
    localparam logic [CNT_W-1:0] TOP_VAL   = CNT_W'(BEAT_DIV);
    localparam logic [CNT_W-1:0] PULSE_LIM = CNT_W'(PULSE_LEN);

    // R3
    beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (cnt_q < TOP_VAL));

    // R4
    early_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && beat_mode && cnt_q == LAST_VAL) |=> (cnt_q == '0));

    // R6
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_mode != mode_q) |=> (cnt_q == '0));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_mode == mode_q && !(mode_q && cnt_q == LAST_VAL))
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R2
    pitch_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_mode |=> (spk_out == cnt_q[TAP_BIT]));

    // R5
    beat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_mode |=> (spk_out == (cnt_q < PULSE_LIM)));
endmodule

bind tone_beat_divider tbd_checker #(
    .CNT_W     (CNT_W),
    .TAP_BIT   (TAP_BIT),
    .BEAT_DIV  (BEAT_DIV),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk       (clk_osc),
    .rst_n     (rst_n),
    .beat_mode (beat_mode),
    .mode_q    (mode_q),
    .cnt_q     (cnt_q),
    .spk_out   (spk_out)
);

// File: tb/sim_tone_beat_divider.sv
// Bench for the tone/beat divider: a vector walk followed by directed cases.
module sim_tone_beat_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       beat_mode = 1'b0;
    logic       spk_out;
    logic [5:0] test_low;
    logic       test_msb;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    tone_beat_divider u0 (
        .clk_osc   (clk),
        .rst_n     (rst_n),
        .beat_mode (beat_mode),
        .spk_out   (spk_out),
        .test_low  (test_low),
        .test_msb  (test_msb)
    );

    // {mode, edges, exp test_low, exp test_msb, exp spk_out}
    localparam int NV = 16;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 16'd31,   6'd31, 1'b0, 1'b0},  // R2 low half
        {1'b0, 16'd1,    6'd32, 1'b0, 1'b1},  // R2 rise at 32
        {1'b0, 16'd31,   6'd63, 1'b0, 1'b1},  // R2
        {1'b0, 16'd1,    6'd0,  1'b0, 1'b0},  // R2 period 64
        {1'b0, 16'd1983, 6'd63, 1'b0, 1'b1},  // R7 count 2047
        {1'b0, 16'd1,    6'd0,  1'b1, 1'b0},  // R7 msb at 2048
        {1'b0, 16'd1792, 6'd0,  1'b1, 1'b0},  // R4 pitch passes 3840
        {1'b0, 16'd256,  6'd0,  1'b0, 1'b0},  // R4 pitch wraps at 4096
        {1'b1, 16'd1,    6'd0,  1'b0, 1'b1},  // R6 switch clears, pulse on
        {1'b1, 16'd15,   6'd15, 1'b0, 1'b1},  // R5
        {1'b1, 16'd1,    6'd16, 1'b0, 1'b0},  // R5 pulse ends at 16
        {1'b1, 16'd3823, 6'd63, 1'b1, 1'b0},  // R3 count 3839
        {1'b1, 16'd1,    6'd0,  1'b0, 1'b1},  // R4 early wrap to 0
        {1'b1, 16'd16,   6'd16, 1'b0, 1'b0},  // R5
        {1'b0, 16'd1,    6'd0,  1'b0, 1'b0},  // R6 back to pitch
        {1'b0, 16'd32,   6'd32, 1'b0, 1'b1}   // R6 full first half period
    };

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_all(input string req, input int lo, input int msb, input int spk);
        check({req, " test_low"}, int'(test_low), lo);
        check({req, " test_msb"}, int'(test_msb), msb);
        check({req, " spk_out"}, int'(spk_out), spk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int highs;
        int rise_at;
        logic prev;
        repeat (3) @(negedge clk);
        check_all("R1 reset", 0, 0, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            beat_mode = VEC[i][24];
            repeat (int'(VEC[i][23:8])) @(negedge clk);
            check_all($sformatf("vector %0d", i), int'(VEC[i][7:2]),
                      int'(VEC[i][1]), int'(VEC[i][0]));
        end

        // R5 R3: pulse width and period over one full beat span
        beat_mode = 1'b1;
        @(negedge clk);
        highs = 0;
        rise_at = -1;
        prev = spk_out;
        for (int k = 1; k <= 3840; k++) begin
            @(negedge clk);
            if (spk_out) highs++;
            if (spk_out && !prev && rise_at < 0) rise_at = k;
            prev = spk_out;
        end
        check("R5 pulse width", highs, 16);
        check("R3 beat period", rise_at, 3840);

        // R6: switch in the middle of a period gives a full first half
        repeat (100) @(negedge clk);
        beat_mode = 1'b0;
        repeat (32) @(negedge clk);
        check_all("R6 mid-period switch", 31, 0, 0);

        // R1: reset in the middle of a run, then leave reset in beat mode
        beat_mode = 1'b1;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1 reset mid-run", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R6 beat after reset", 0, 0, 1);
        repeat (16) @(negedge clk);
        check_all("R5 beat after reset", 16, 0, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule